// File: doc/BRIEF.md
# Paged Serial Flash Program Sequencer

This block writes a stream of bytes into a serial NOR flash. A single start request carries a 24-bit flash address, a byte count and a page size. The block then drives a byte-exchange SPI engine and its own active-low chip select through the whole program flow, and pulls data from a ready/valid byte input as it needs it.

Each page is programmed in four steps. The block sets the write-enable latch and reads status back to confirm the latch is set. It then opens a program command carrying the address and sends data bytes until either the page boundary or the last byte is reached. At a page boundary it closes the command, polls the flash status until the flash is no longer busy, and starts the next page. The result is held on `done_o` or `error_o` until the next accepted start. A host that wants to stop early raises `abort_i`. The block honours it when it is waiting for the next data byte.

Top module: `spi_nor_pgm_seq`

## Requirements
- R1: After reset the block is idle: `cs_n` is 1, and `done_o`, `error_o`, `din_ready` and `spi_start` are all 0.
- R2: A start with count 0 sets `done_o` in the next cycle, leaves `error_o` at 0 and exchanges no byte on the bus. This holds whatever the page size is.
- R3: A start with a nonzero count and a page size that is zero or not a power of two sets `error_o` in the next cycle and exchanges no byte.
- R4: Every page begins with the write-enable opcode 0x06 as the only byte of its own chip-select frame. This is followed by a separate two-byte frame: the status-read opcode 0x05, then the dummy byte 0x00. The byte received during the dummy byte is the status, with bit 1 as the write-enable latch and bit 0 as busy.
- R5: If status bit 1 reads 0 after write-enable, chip select goes high, `error_o` is set and no program command is sent.
- R6: A program frame is opcode 0x02, then address bits 23:16, 15:8 and 7:0 in that order, then the accepted input bytes in acceptance order.
- R7: The first page end is the smallest multiple of the page size that is strictly above the start address. Each program frame stops at the current page end or at the last byte, whichever comes first. The page end then moves up by one page size.
- R8: After each page frame that is not the last, the block repeats 0x05 + 0x00 status frames until status bit 0 reads 0. Only then does it issue the next write-enable.
- R9: After the final byte, chip select goes high and `done_o` is set with `error_o` at 0.
- R10: When `abort_i` is high while the block waits for a data byte, no further byte is accepted. Chip select goes high and `done_o` is set.
- R11: `spi_start` is raised only while chip select is low and the engine is not busy. At most one exchange is in flight.
- R12: `din_ready` is high only inside an open program frame, once the address has been sent. The byte accepted in a cycle is the one presented on `spi_tx` with `spi_start` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, taken when idle |
| addr_i | input | 24 | First flash address |
| count_i | input | 24 | Number of bytes to write |
| page_size_i | input | 16 | Flash page size in bytes |
| abort_i | input | 1 | Stop request, honoured while waiting for data |
| din_data | input | 8 | Input data byte |
| din_valid | input | 1 | Input byte valid |
| din_ready | output | 1 | Block takes the input byte |
| done_o | output | 1 | Transfer finished (held until next start) |
| error_o | output | 1 | Transfer failed (held until next start) |
| spi_tx | output | 8 | Byte to send, valid with spi_start |
| spi_start | output | 1 | Launch one byte exchange |
| spi_busy | input | 1 | Engine exchanging a byte |
| spi_rx | input | 8 | Byte received, valid once spi_busy is low |
| cs_n | output | 1 | Flash chip select, active low |

## Verification
The assertions assume the SPI engine raises `spi_busy` on the clock edge at which it sees `spi_start`. They also assume the engine holds `spi_busy` until `spi_rx` carries the received byte. The bench's engine model obeys this with a fixed three-cycle exchange. The bench does not check page-size or address legality itself; it relies on the block's own start checks for that. Its flash model answers status reads from a write-enable latch and a busy counter. The sweeps use small power-of-two pages, so every boundary case is reached in a few bytes. The data source stalls on a regular pattern, so byte acceptance is exercised both back to back and with gaps.

// File: rtl/spi_nor_pgm_pkg.sv
package spi_nor_pgm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WREN, ST_GAP, ST_SR_OP, ST_SR_DUM, ST_PP_OP,
    ST_AD_HI, ST_AD_MID, ST_AD_LO, ST_DIN_WAIT, ST_DIN_TX
  } seq_state_t;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] SR_DUMMY = 8'h00;
  localparam int WEL_BIT = 1;
  localparam int WIP_BIT = 0;

  // nonzero and exactly one bit set
  function automatic logic size_ok(input logic [31:0] v);
    return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
  endfunction

  // smallest multiple of ps strictly above a (ps a power of two)
  function automatic logic [32:0] first_page_end(input logic [31:0] a, input logic [31:0] ps);
    return {1'b0, a & ~(ps - 32'd1)} + {1'b0, ps};
  endfunction

  function automatic logic sr_bit(input logic [7:0] sr, input int pos);
    return (sr & 8'(1 << pos)) != 8'd0;
  endfunction

endpackage

// File: rtl/spi_nor_xchg.sv
module spi_nor_xchg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic [7:0] tx_i,
  output logic       ack_o,
  output logic [7:0] rx_o,
  output logic       spi_start_o,
  output logic [7:0] spi_tx_o,
  input  logic       spi_busy_i,
  input  logic [7:0] spi_rx_i
);
  logic inflight_q;

  assign spi_start_o = req_i && !inflight_q;
  assign spi_tx_o    = tx_i;
  assign ack_o       = inflight_q && !spi_busy_i;
  assign rx_o        = spi_rx_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           inflight_q <= 1'b0;
    else if (ack_o)       inflight_q <= 1'b0;
    else if (spi_start_o) inflight_q <= 1'b1;
  end
endmodule

// File: rtl/spi_nor_page_track.sv
module spi_nor_page_track #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 24,
  parameter int PS_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [PS_W-1:0]   ps_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              page_hit_o
);
  import spi_nor_pgm_pkg::*;
  localparam int PE_W = ADDR_W + 1;

  logic [PE_W-1:0]  addr_q, pend_q, addr_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic [PS_W-1:0]  ps_q;

  assign addr_nxt   = addr_q + PE_W'(1);
  assign page_hit_o = (addr_nxt == pend_q);
  assign last_o     = (cnt_q == CNT_W'(1));
  assign addr_o     = addr_q[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      pend_q <= '0;
      cnt_q  <= '0;
      ps_q   <= '0;
    end else if (load_i) begin
      addr_q <= {1'b0, addr_i};
      cnt_q  <= cnt_i;
      ps_q   <= ps_i;
      pend_q <= PE_W'(first_page_end(32'(addr_i), 32'(ps_i)));
    end else if (step_i) begin
      addr_q <= addr_nxt;
      cnt_q  <= cnt_q - CNT_W'(1);
      if (page_hit_o) pend_q <= pend_q + PE_W'(ps_q);
    end
  end
endmodule

// File: rtl/spi_nor_pgm_seq.sv
module spi_nor_pgm_seq #(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 24,
  parameter int PS_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [PS_W-1:0]   page_size_i,
  input  logic              abort_i,
  input  logic [7:0]        din_data,
  input  logic              din_valid,
  output logic              din_ready,
  output logic              done_o,
  output logic              error_o,
  output logic [7:0]        spi_tx,
  output logic              spi_start,
  input  logic              spi_busy,
  input  logic [7:0]        spi_rx,
  output logic              cs_n
);
  import spi_nor_pgm_pkg::*;

  seq_state_t state_q, state_d, gap_nxt_q, gap_nxt_d;
  logic       poll_q, poll_d;
  logic [7:0] dbyte_q, tx_sel, xfer_rx;
  logic       done_q, err_q, cs_n_q;
  logic       xfer_req, xfer_ack;
  logic       trk_last, trk_hit;
  logic [ADDR_W-1:0] trk_addr;
  logic [23:0] a24;

  // named internal events
  logic seq_idle, start_take, byte_take, abort_take, wel_fail, data_step;
  logic done_set, err_set;

  assign seq_idle   = (state_q == ST_IDLE);
  assign start_take = seq_idle && start_i;
  assign din_ready  = (state_q == ST_DIN_WAIT) && !abort_i;
  assign byte_take  = din_ready && din_valid;
  assign abort_take = (state_q == ST_DIN_WAIT) && abort_i;
  assign data_step  = (state_q == ST_DIN_TX) && xfer_ack;
  assign wel_fail   = (state_q == ST_SR_DUM) && xfer_ack && !poll_q
                      && !sr_bit(xfer_rx, WEL_BIT);
  assign a24        = 24'(trk_addr);

  assign xfer_req = (state_q == ST_WREN)  || (state_q == ST_SR_OP) ||
                    (state_q == ST_SR_DUM) || (state_q == ST_PP_OP) ||
                    (state_q == ST_AD_HI) || (state_q == ST_AD_MID) ||
                    (state_q == ST_AD_LO) || (state_q == ST_DIN_TX);

  always_comb begin
    case (state_q)
      ST_WREN:   tx_sel = OP_WREN;
      ST_SR_OP:  tx_sel = OP_RDSR;
      ST_SR_DUM: tx_sel = SR_DUMMY;
      ST_PP_OP:  tx_sel = OP_PROG;
      ST_AD_HI:  tx_sel = a24[23:16];
      ST_AD_MID: tx_sel = a24[15:8];
      ST_AD_LO:  tx_sel = a24[7:0];
      ST_DIN_TX: tx_sel = dbyte_q;
      default:   tx_sel = 8'h00;
    endcase
  end

  spi_nor_xchg u_xchg (
    .clk(clk), .rst_n(rst_n), .req_i(xfer_req), .tx_i(tx_sel),
    .ack_o(xfer_ack), .rx_o(xfer_rx), .spi_start_o(spi_start),
    .spi_tx_o(spi_tx), .spi_busy_i(spi_busy), .spi_rx_i(spi_rx)
  );

  spi_nor_page_track #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PS_W(PS_W)) u_track (
    .clk(clk), .rst_n(rst_n),
    .load_i(start_take && (count_i != '0) && size_ok(32'(page_size_i))),
    .addr_i(addr_i), .cnt_i(count_i), .ps_i(page_size_i),
    .step_i(data_step), .addr_o(trk_addr), .last_o(trk_last), .page_hit_o(trk_hit)
  );

  always_comb begin
    state_d   = state_q;
    gap_nxt_d = gap_nxt_q;
    poll_d    = poll_q;
    done_set  = 1'b0;
    err_set   = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        if (count_i == '0)                      done_set = 1'b1;
        else if (!size_ok(32'(page_size_i)))    err_set  = 1'b1;
        else begin state_d = ST_WREN; poll_d = 1'b0; end
      end
      ST_WREN: if (xfer_ack) begin state_d = ST_GAP; gap_nxt_d = ST_SR_OP; end
      ST_GAP:  state_d = gap_nxt_q;
      ST_SR_OP: if (xfer_ack) state_d = ST_SR_DUM;
      ST_SR_DUM: if (xfer_ack) begin
        state_d = ST_GAP;
        if (poll_q) begin
          if (sr_bit(xfer_rx, WIP_BIT)) gap_nxt_d = ST_SR_OP;
          else begin gap_nxt_d = ST_WREN; poll_d = 1'b0; end
        end else if (!sr_bit(xfer_rx, WEL_BIT)) begin
          state_d = ST_IDLE; err_set = 1'b1;
        end else gap_nxt_d = ST_PP_OP;
      end
      ST_PP_OP:  if (xfer_ack) state_d = ST_AD_HI;
      ST_AD_HI:  if (xfer_ack) state_d = ST_AD_MID;
      ST_AD_MID: if (xfer_ack) state_d = ST_AD_LO;
      ST_AD_LO:  if (xfer_ack) state_d = ST_DIN_WAIT;
      ST_DIN_WAIT: begin
        if (abort_i) begin state_d = ST_IDLE; done_set = 1'b1; end
        else if (din_valid) state_d = ST_DIN_TX;
      end
      ST_DIN_TX: if (xfer_ack) begin
        if (trk_last) begin state_d = ST_IDLE; done_set = 1'b1; end
        else if (trk_hit) begin state_d = ST_GAP; gap_nxt_d = ST_SR_OP; poll_d = 1'b1; end
        else state_d = ST_DIN_WAIT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      gap_nxt_q <= ST_IDLE;
      poll_q    <= 1'b0;
      dbyte_q   <= 8'h00;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      cs_n_q    <= 1'b1;
    end else begin
      state_q   <= state_d;
      gap_nxt_q <= gap_nxt_d;
      poll_q    <= poll_d;
      if (byte_take) dbyte_q <= din_data;
      done_q    <= start_take ? done_set : (done_q | done_set);
      err_q     <= start_take ? err_set  : (err_q | err_set);
      cs_n_q    <= (state_d == ST_IDLE) || (state_d == ST_GAP);
    end
  end

  assign done_o  = done_q;
  assign error_o = err_q;
  assign cs_n    = cs_n_q;
endmodule

// File: rtl/spi_nor_pgm_chk.sv
module spi_nor_pgm_chk #(
  parameter int CNT_W = 24,
  parameter int PS_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count_i,
  input logic [PS_W-1:0]  page_size_i,
  input logic             spi_start,
  input logic             spi_busy,
  input logic [7:0]       spi_tx,
  input logic             cs_n,
  input logic             din_ready,
  input logic [7:0]       din_data,
  input logic             done_o,
  input logic             error_o,
  input logic             seq_idle,
  input logic             start_take,
  input logic             byte_take,
  input logic             abort_take,
  input logic             wel_fail
);
  logic bad_size;
  assign bad_size = (page_size_i == '0) || ((page_size_i & (page_size_i - PS_W'(1))) != '0);

  assert_idle_cs_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    seq_idle |-> cs_n);
  assert_zero_count_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_take && count_i == '0) |=> (done_o && !error_o && cs_n));
  assert_bad_size_error_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_take && count_i != '0 && bad_size) |=> (error_o && !done_o && cs_n));
  assert_wel_fail_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wel_fail |=> (error_o && cs_n));
  assert_abort_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_take |=> (cs_n && done_o && !din_ready));
  assert_start_framed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> (!cs_n && !spi_busy));
  assert_ready_framed_R12: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> !cs_n);
  assert_byte_forwarded_R12: assert property (@(posedge clk) disable iff (!rst_n)
    byte_take |=> (spi_start && spi_tx == $past(din_data)));
  assert_result_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && error_o));
endmodule

bind spi_nor_pgm_seq spi_nor_pgm_chk #(.CNT_W(CNT_W), .PS_W(PS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .count_i(count_i), .page_size_i(page_size_i),
  .spi_start(spi_start), .spi_busy(spi_busy), .spi_tx(spi_tx), .cs_n(cs_n),
  .din_ready(din_ready), .din_data(din_data), .done_o(done_o), .error_o(error_o),
  .seq_idle(seq_idle), .start_take(start_take), .byte_take(byte_take),
  .abort_take(abort_take), .wel_fail(wel_fail)
);

// File: tb/spi_nor_pgm_seq_test.sv
`timescale 1ns/1ps
module spi_nor_pgm_seq_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, start_i = 1'b0, abort_i = 1'b0;
  logic [23:0] addr_i = '0, count_i = '0;
  logic [15:0] page_size_i = '0;
  logic [7:0] din_data = '0, spi_tx, spi_rx;
  logic din_valid = 1'b0, din_ready, done_o, error_o, spi_start, spi_busy, cs_n;

  spi_nor_pgm_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .count_i(count_i),
    .page_size_i(page_size_i), .abort_i(abort_i), .din_data(din_data),
    .din_valid(din_valid), .din_ready(din_ready), .done_o(done_o), .error_o(error_o),
    .spi_tx(spi_tx), .spi_start(spi_start), .spi_busy(spi_busy), .spi_rx(spi_rx),
    .cs_n(cs_n)
  );

  localparam int BUSY_READS = 2;
  int n_checks = 0, n_errors = 0, cyc = 0;

  // bench knobs
  logic mdl_clr = 1'b0, deny_wel = 1'b0, feed_on = 1'b0;
  int feed_lim = 0, stall_v = 0, seed_v = 0;

  // engine + flash model state
  int eng_cnt, bi, n_bytes, n_pp, n_rdsr, n_wren, n_data, viol, busyp, maddr, feed_idx;
  logic wel, cs_prev;
  logic [7:0] op;
  int pp_addr [64];
  int pp_len [64];
  logic [7:0] data_log [512];

  function automatic logic [7:0] pat(input int k, input int s);
    return 8'((k * 29 + s * 13 + 5) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n || mdl_clr) begin
      spi_busy <= 1'b0; spi_rx <= 8'hFF; eng_cnt = 0; feed_idx <= 0;
      bi = 0; n_bytes = 0; n_pp = 0; n_rdsr = 0; n_wren = 0; n_data = 0; viol = 0;
      busyp = 0; maddr = 0; wel = 1'b0; op = 8'h00; cs_prev = 1'b1;
    end else begin
      if (din_valid && din_ready) feed_idx <= feed_idx + 1;
      if (cs_n && !cs_prev) begin
        case (op)
          8'h06: begin n_wren++; if (bi != 1) viol++; if (!deny_wel) wel = 1'b1; end
          8'h05: begin n_rdsr++; if (bi != 2) viol++; if (busyp > 0) busyp--; end
          8'h02: begin pp_addr[n_pp] = maddr; pp_len[n_pp] = bi - 4; n_pp++;
                       wel = 1'b0; busyp = BUSY_READS; end
          default: viol++;
        endcase
        bi = 0; maddr = 0;
      end
      cs_prev = cs_n;
      if (spi_start) begin
        logic [7:0] resp;
        resp = 8'hFF;
        if (bi == 0) begin
          op = spi_tx;
          if (spi_tx == 8'h02 && (!wel || busyp > 0)) viol++;
        end else if (op == 8'h05 && bi == 1) begin
          resp = {6'b0, wel, busyp > 0};
        end else if (op == 8'h02) begin
          if (bi <= 3) maddr = (maddr << 8) | int'(spi_tx);
          else begin data_log[n_data] = spi_tx; n_data++; end
        end
        bi++; n_bytes++;
        spi_busy <= 1'b1; eng_cnt = 2; spi_rx <= resp;
      end else if (spi_busy) begin
        if (eng_cnt == 0) spi_busy <= 1'b0;
        else eng_cnt--;
      end
    end
  end

  always @(negedge clk) begin
    din_data  = pat(feed_idx, seed_v);
    din_valid = feed_on && (feed_idx < feed_lim) && (stall_v == 0 || (cyc % 3) != 0);
  end

  always @(posedge clk) if (cyc > 190000) begin
    n_errors++; n_checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  task automatic launch(input int a, input int n, input int ps, input int lim, input int stall, input int seed);
    @(negedge clk); mdl_clr = 1'b1;
    @(negedge clk); mdl_clr = 1'b0;
    feed_lim = lim; stall_v = stall; seed_v = seed; feed_on = 1'b1;
    addr_i = 24'(a); count_i = 24'(n); page_size_i = 16'(ps); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_end(input string req);
    int t = 0;
    while (!(done_o || error_o) && t < 4000) begin @(negedge clk); t++; end
    check(t < 4000, req, "finish within limit", t, 4000);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_xfer(input int a, input int n, input int ps, input int stall, input int seed);
    int cur, rem, pe, len, k, bad, bad_data;
    launch(a, n, ps, n, stall, seed);
    wait_end("R9");
    feed_on = 1'b0;
    check(done_o && !error_o && cs_n, "R9", "done, no error, cs high", {done_o, error_o, cs_n}, 3'b101);
    check(!din_ready, "R12", "no ready after finish", din_ready, 0);
    // R7: expected page split
    cur = a; rem = n; k = 0; bad = 0;
    while (rem > 0) begin
      pe = (cur / ps + 1) * ps;
      len = (pe - cur < rem) ? pe - cur : rem;
      if (k < n_pp && (pp_addr[k] != cur || pp_len[k] != len)) bad++;
      k++; cur += len; rem -= len;
    end
    check(n_pp == k, "R7", "program frame count", n_pp, k);
    check(bad == 0, "R7", "frame address/length mismatches", bad, 0);
    bad_data = 0;
    for (int i = 0; i < n; i++) if (data_log[i] !== pat(i, seed)) bad_data++;
    check(n_data == n && bad_data == 0, "R6", "data bytes in order", n_data - bad_data, n);
    check(viol == 0 && n_wren == n_pp, "R4", "write-enable per page, framing", viol, 0);
    check(n_rdsr == n_pp + (n_pp - 1) * (BUSY_READS + 1), "R8", "status reads incl. busy polls",
          n_rdsr, n_pp + (n_pp - 1) * (BUSY_READS + 1));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n && !done_o && !error_o && !din_ready && !spi_start, "R1", "idle after reset",
          {cs_n, done_o, error_o, din_ready, spi_start}, 5'b10000);

    // R2: zero count, even with a zero page size
    launch(0, 0, 0, 0, 0, 0);
    check(done_o && !error_o, "R2", "zero count done next cycle", {done_o, error_o}, 2'b10);
    repeat (4) @(negedge clk);
    check(n_bytes == 0 && cs_n, "R2", "no bus traffic", n_bytes, 0);

    // R3: bad page sizes
    launch(5, 7, 12, 0, 0, 0);
    check(error_o && !done_o, "R3", "size 12 error", {done_o, error_o}, 2'b01);
    repeat (4) @(negedge clk);
    check(n_bytes == 0, "R3", "size 12 no traffic", n_bytes, 0);
    launch(5, 7, 0, 0, 0, 0);
    check(error_o && !done_o, "R3", "size 0 error", {done_o, error_o}, 2'b01);

    // R5: write-enable latch never sets
    deny_wel = 1'b1;
    launch(3, 6, 8, 6, 0, 1);
    wait_end("R5");
    check(error_o && !done_o && cs_n, "R5", "error with cs high", {done_o, error_o, cs_n}, 3'b011);
    check(n_pp == 0 && n_wren == 1 && n_rdsr == 1, "R5", "no program frame", n_pp, 0);
    deny_wel = 1'b0;

    // R10: abort after three bytes
    launch(2, 10, 8, 3, 0, 2);
    while (feed_idx < 3) @(negedge clk);
    repeat (20) @(negedge clk);
    abort_i = 1'b1;
    wait_end("R10");
    abort_i = 1'b0; feed_on = 1'b0;
    check(done_o && !error_o && cs_n, "R10", "abort ends with done", {done_o, error_o, cs_n}, 3'b101);
    check(n_pp == 1 && pp_len[0] == 3 && n_data == 3, "R10", "bytes sent before abort", n_data, 3);

    // top of the address space
    run_xfer(24'hFFFFFC, 4, 4, 0, 3);

    // sweeps over small pages
    for (int ps = 4; ps <= 8; ps += 4)
      for (int a = 0; a <= ps + 2; a++)
        for (int n = 1; n <= 2 * ps + 2; n++)
          run_xfer(a, n, ps, (a + n) % 2, a * 31 + n);

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule